// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

The block opens a door after a fixed sequence of three 4-bit digits is keyed in. Each time a "digit valid" strobe is high on a clock edge, the entered digit is sampled and compared with the stored digit for the current stage. A correct digit moves the lock one stage forward. After the third correct digit the door output goes high. A wrong digit at any stage sends the lock into a trapped error state. Only a reset releases the lock from the open or the error state.

The design has two parts. A datapath holds the three stored digits, selects one of them with a one-hot select, and checks it for equality with the entered digit. A controller, a Moore state machine, drives that select and produces the door output. The state code is chosen so that the select is simply the low three state bits and the door output is the top state bit. The stored sequence is set by parameters and defaults to 3, then 4, then 2.

Top module: `combo_lock`

## Requirements
- R1: A synchronous active-high reset puts the lock in the first entry stage with the door closed, whatever the strobe and digit inputs are. Reset takes priority over every other input.
- R2: In an entry stage, a cycle with the strobe low leaves the stage unchanged, whatever the digit input is.
- R3: In an entry stage, a strobe with the matching stored digit advances the lock: stage 1 to stage 2, stage 2 to stage 3, and stage 3 to open.
- R4: In an entry stage, a strobe with a digit that differs from the stored digit for that stage moves the lock to the error state, with the door closed.
- R5: Once open, the lock stays open with the door output at 1 until reset, whatever the strobe and digit inputs are.
- R6: Once in the error state, the lock stays closed until reset, even if the full correct sequence is then entered.
- R7: The door output is registered. It rises on the clock edge that samples the third correct digit, and it is 1 in the open state and nowhere else.
- R8: The default stored sequence is 3, 4, 2, checked in that order. Entering the same digits in another order does not open the lock.
- R9: A strobe held high for several cycles consumes one digit on each cycle it is high.
- R10: The state is coded in 4 bits as stage1=0001, stage2=0010, stage3=0100, open=1000 and error=0000. The one-hot digit select is the low three bits of the state, and the door output is bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to entry stage 1 |
| digit_vld | input | 1 | Strobe: sample digit_in on this edge |
| digit_in | input | 4 | Digit being entered |
| door_open | output | 1 | 1 while the lock is open (registered) |

## Verification
Every result shows up on door_open one clock edge after the inputs that caused it. This holds for the reset in R1, for the step into open in R3 and R7, and for the fall into error in R4. The bench sets the inputs on the falling edge and lets one rising edge pass. It updates its own model of the state from those inputs and compares door_open with the model shortly after that edge, before the next inputs are set. The lock's state is only visible through door_open. For this reason the hold, error and ordering cases (R2, R4, R6, R8) are followed by a later digit sequence, and its effect on door_open reveals the stage the lock was actually in.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    localparam int NUM_STAGES = 3;
    localparam int STATE_W    = NUM_STAGES + 1;

    typedef enum logic [STATE_W-1:0] {
        LK_ERROR  = 4'b0000,
        LK_STAGE1 = 4'b0001,
        LK_STAGE2 = 4'b0010,
        LK_STAGE3 = 4'b0100,
        LK_OPEN   = 4'b1000
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
    } lock_regs_t;

endpackage

// File: rtl/combo_lock_datapath.sv
module combo_lock_datapath #(
    parameter int VAL_W = 4,
    parameter int NUM   = 3,
    parameter logic [NUM*VAL_W-1:0] CODE = {4'd2, 4'd4, 4'd3}
) (
    input  logic [NUM-1:0]   sel,
    input  logic [VAL_W-1:0] digit,
    output logic             match
);

    logic [VAL_W-1:0] term [NUM];
    logic [VAL_W-1:0] picked;

    // One AND-mask per stored digit; the select is one-hot so an OR merges them
    for (genvar i = 0; i < NUM; i++) begin : g_term
        assign term[i] = {VAL_W{sel[i]}} & CODE[i*VAL_W +: VAL_W];
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM; i++) begin
            picked = picked | term[i];
        end
    end

    assign match = (picked == digit);

endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import combo_lock_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strobe,
    input  logic                  match,
    output logic [NUM_STAGES-1:0] sel,
    output logic                  open_o
);

    lock_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            LK_STAGE1, LK_STAGE2, LK_STAGE3: begin
                if (strobe) begin
                    if (match) regs_d.state = lock_state_e'(regs_q.state << 1);
                    else       regs_d.state = LK_ERROR;
                end
            end
            LK_OPEN:  regs_d.state = LK_OPEN;
            LK_ERROR: regs_d.state = LK_ERROR;
            default:  regs_d.state = LK_ERROR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{state: LK_STAGE1};
        else     regs_q <= regs_d;
    end

    assign sel    = regs_q.state[NUM_STAGES-1:0];
    assign open_o = regs_q.state[NUM_STAGES];

    p_reset_stage1_r1: assert property (@(posedge clk) rst |=> regs_q.state == LK_STAGE1);

    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (!strobe && sel != '0) |=> $stable(regs_q.state));

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && match && regs_q.state == LK_STAGE2) |=> regs_q.state == LK_STAGE3);

    p_miss_error_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !match && sel != '0) |=> regs_q.state == LK_ERROR);

    p_open_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == LK_OPEN) |=> regs_q.state == LK_OPEN);

    p_error_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == LK_ERROR) |=> regs_q.state == LK_ERROR);

    p_code_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(regs_q.state));

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int VAL_W = 4,
    parameter logic [NUM_STAGES*VAL_W-1:0] CODE = {4'd2, 4'd4, 4'd3}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             digit_vld,
    input  logic [VAL_W-1:0] digit_in,
    output logic             door_open
);

    logic [NUM_STAGES-1:0] sel;
    logic                  match;

    combo_lock_datapath #(
        .VAL_W (VAL_W),
        .NUM   (NUM_STAGES),
        .CODE  (CODE)
    ) u_dp (
        .sel   (sel),
        .digit (digit_in),
        .match (match)
    );

    combo_lock_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .strobe (digit_vld),
        .match  (match),
        .sel    (sel),
        .open_o (door_open)
    );

    // Third digit right: door must be open on the next edge
    p_last_digit_opens_r7: assert property (@(posedge clk) disable iff (rst)
        (sel[NUM_STAGES-1] && digit_vld && match) |=> door_open);

    // Door and select never active together
    p_open_excl_r10: assert property (@(posedge clk) disable iff (rst)
        door_open |-> (sel == '0));

    // Stage 1 compares against the first stored digit
    p_first_digit_r8: assert property (@(posedge clk) disable iff (rst)
        (sel[0] && digit_vld && digit_in == CODE[VAL_W-1:0]) |=> sel[1]);

endmodule

// File: tb/combo_lock_test.sv
module combo_lock_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       digit_vld = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic       door_open;

    int n_checks = 0;
    int n_errors = 0;
    int exp_st   = 0;   // 0=error 1..3=stage 4=open
    bit done     = 0;

    localparam int CODE0 = 3, CODE1 = 4, CODE2 = 2;

    always #5 clk = ~clk;

    combo_lock uut (
        .clk       (clk),
        .rst       (rst),
        .digit_vld (digit_vld),
        .digit_in  (digit_in),
        .door_open (door_open)
    );

    function automatic int code_for(input int st);
        case (st)
            1: return CODE0;
            2: return CODE1;
            3: return CODE2;
            default: return 0;
        endcase
    endfunction

    function automatic int model_next(input int st, input bit r, input bit n, input int v);
        if (r) return 1;
        if (st == 0 || st == 4) return st;
        if (!n) return st;
        if (v == code_for(st)) return st + 1;
        return 0;
    endfunction

    function automatic string tag_for(input int st, input bit r, input bit n, input int v);
        if (r) return "R1";
        if (st == 4) return "R5";
        if (st == 0) return "R6";
        if (!n) return "R2";
        if (v == code_for(st)) return (st == 3) ? "R7" : "R3";
        return "R4";
    endfunction

    task automatic check(input string req, input bit exp);
        n_checks++;
        if (door_open !== exp) begin
            n_errors++;
            $display("FAIL %s: door_open=%0b expected %0b", req, door_open, exp);
        end
    endtask

    task automatic cycle(input bit r, input bit n, input int v, input string req);
        string t;
        @(negedge clk);
        rst = r; digit_vld = n; digit_in = 4'(v);
        t = (req == "") ? tag_for(exp_st, r, n, v) : req;
        @(posedge clk);
        exp_st = model_next(exp_st, r, n, v);
        #1;
        check(t, exp_st == 4);
    endtask

    task automatic enter3(input int a, input int b, input int c, input string req);
        cycle(0, 1, a, req);
        cycle(0, 1, b, req);
        cycle(0, 1, c, req);
    endtask

    initial begin
        void'($urandom(32'd17));
        // R1: reset wins over strobe with a correct digit
        cycle(1, 1, CODE0, "R1");
        cycle(1, 1, CODE0, "R1");
        // R2 gaps, R3 advance, R7 door rises only after third digit
        cycle(0, 1, CODE0, "R3");
        cycle(0, 0, 9, "R2");
        cycle(0, 0, CODE1, "R2");
        cycle(0, 1, CODE1, "R3");
        cycle(0, 0, 0, "R2");
        cycle(0, 1, CODE2, "R7");
        // R5: open ignores strobes and wrong digits
        cycle(0, 1, 15, "R5");
        cycle(0, 1, 0, "R5");
        cycle(0, 0, 7, "R5");
        // R4 then R6: miss at stage 1, correct sequence afterwards stays closed
        cycle(1, 0, 0, "R1");
        cycle(0, 1, 5, "R4");
        enter3(CODE0, CODE1, CODE2, "R6");
        // R8: wrong order
        cycle(1, 0, 0, "R1");
        enter3(CODE2, CODE1, CODE0, "R8");
        cycle(0, 1, CODE2, "R8");
        // R4 at last stage
        cycle(1, 0, 0, "R1");
        enter3(CODE0, CODE1, 7, "R4");
        // R9: strobe held high three cycles consumes three digits
        cycle(1, 0, 0, "R1");
        enter3(CODE0, CODE1, CODE2, "R9");
        // R1: reset in stage 3 returns to stage 1
        cycle(1, 0, 0, "R1");
        cycle(0, 1, CODE0, "R3");
        cycle(0, 1, CODE1, "R3");
        cycle(1, 1, CODE2, "R1");
        enter3(CODE0, CODE1, CODE2, "R1");
        // R10: a stage-2 digit offered at stage 1 is a miss
        cycle(1, 0, 0, "R1");
        cycle(0, 1, CODE1, "R10");
        enter3(CODE0, CODE1, CODE2, "R10");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit r, n;
            int v;
            r = ($urandom % 40) == 0;
            n = ($urandom % 3) != 0;
            v = (($urandom % 5) != 0) ? code_for(exp_st) : int'($urandom % 16);
            cycle(r, n, v, "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule